// File: doc/BRIEF.md
# Soft Mute Sequencer

This block decides when an audio output path is allowed to drive sound and how it gets there. It watches a sample-rate validity flag, a bit-clock presence flag, an active-low mute pin and a stopped-clocks indication. From these it sequences a line-driver enable, a line-driver ramp signal and a digital attenuation index. Every duration is counted in sample strobes, not in system clocks.

After reset the block waits for its first sample strobe and then sits in a muted state. It unmutes only when every enabling condition is present. Unmuting has two phases. First the line driver ramps for a fixed number of samples; that number is longer the first time after reset than on any later unmute. Then the digital volume is released step by step, 0.5 dB per sample, from full mute to full scale. When any condition is lost, the volume is walked back down before the driver is switched off. When the clocks stop and the mute pin is low, the output is cut at once with no ramp.

Top module: `smute_seq`

## Requirements
- R1: After reset the outputs are drv_en=0, drv_ramp=0 and atten=256 (full mute). The block stays muted until at least one sample_tick has been seen, whatever the other inputs are.
- R2: From the muted state, an unmute starts only when ratio_ok, bclk_seen and mute_n are all 1. If any one of them is 0, drv_en stays 0.
- R3: The first unmute after reset holds drv_en=1, drv_ramp=1 and atten=256 for exactly FIRST_N sample ticks.
- R4: Every later unmute holds drv_ramp=1 for exactly LATER_N sample ticks.
- R5: When the driver ramp ends, atten goes from 256 to 255 on the next tick. It then drops by one per tick and reaches 0 after 256 ticks in total, with drv_ramp=0 throughout.
- R6: In normal operation atten=0 and drv_en=1. Losing any of the three conditions starts a mute process.
- R7: A mute process raises atten by one per tick. Once atten is 255, the next tick sets atten=256 and drv_en=0. Starting from 0, this takes 256 ticks.
- R8: If a condition is lost during the driver ramp or the volume ramp, the mute process starts from the attenuation held at that moment, with no jump.
- R9: When clocks_idle=1 and mute_n=0 (in any state past initialisation), the next cycle shows drv_en=0 and atten=256 with no ramp. The block returns to the muted state once that condition clears.
- R10: The flag that selects the first-unmute duration is cleared only by reset. After a new reset the next unmute again takes FIRST_N ticks.
- R11: Outside an instant mute, atten changes only in a cycle that consumed a sample_tick. Apart from transitions to or from 256, it moves by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_ok | input | 1 | Master-clock to sample-rate ratio is valid |
| bclk_seen | input | 1 | Bit clock is present |
| mute_n | input | 1 | Mute pin, active low |
| clocks_idle | input | 1 | All audio clocks have stopped |
| sample_tick | input | 1 | One-cycle strobe per audio sample |
| drv_en | output | 1 | Line driver enable |
| drv_ramp | output | 1 | Line driver soft ramp in progress |
| atten | output | ATT_W+1 | Attenuation in 0.5 dB steps; 255 = -127.5 dB, 256 = full mute |

## Verification
The assertions assume that sample_tick is a single-cycle strobe, synchronous to clk. They also assume the status inputs are already synchronised to clk, so a level held across an edge is what the sequencer sees. The stimulus changes every input just after a falling edge, so each value is stable at the next rising edge. It issues a tick on every second cycle, which keeps strobes isolated, and it holds conditions for many ticks before changing them. Aborts and instant mutes are applied at chosen points in the driver ramp, the volume ramp and normal operation.

// File: rtl/smute_pkg.sv
package smute_pkg;

  typedef enum logic [2:0] {
    ST_RST,
    ST_INIT,
    ST_MUTE,
    ST_UNMUTE,
    ST_VOLUP,
    ST_NORM,
    ST_DOWN,
    ST_INST
  } seq_st_t;

  typedef enum logic [1:0] {
    VC_HOLD,
    VC_FULL,
    VC_LOUDER,
    VC_SOFTER
  } vol_cmd_t;

endpackage

// File: rtl/smute_timer.sv
module smute_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic          last
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign last = (cnt == CW'(1));

  // R3 / R4: the duration loaded is the one that gets counted down
  a_r3_load_taken: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/smute_vol.sv
module smute_vol
  import smute_pkg::*;
#(
  parameter int ATT_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  vol_cmd_t       cmd,
  output logic [ATT_W:0] atten
);

  localparam int AW = ATT_W + 1;
  localparam logic [ATT_W:0] FULL = {1'b1, {ATT_W{1'b0}}};
  localparam logic [ATT_W:0] MAXA = {1'b0, {ATT_W{1'b1}}};

  logic [ATT_W:0] att_nxt;

  always_comb begin
    unique case (cmd)
      VC_FULL:    att_nxt = FULL;
      VC_LOUDER:  att_nxt = (atten == FULL) ? MAXA :
                            ((atten != '0) ? atten - AW'(1) : atten);
      VC_SOFTER:  att_nxt = (atten >= MAXA) ? FULL : atten + AW'(1);
      default:    att_nxt = atten;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atten <= FULL;
    end else if (cmd != VC_HOLD) begin
      atten <= att_nxt;
    end
  end

  // R5: a louder step always lowers attenuation
  a_r5_louder_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == VC_LOUDER && atten != '0) |=> (atten < $past(atten)));

  // R7: a softer step always raises attenuation
  a_r7_softer_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == VC_SOFTER && atten != FULL) |=> (atten > $past(atten)));

endmodule

// File: rtl/smute_seq.sv
module smute_seq
  import smute_pkg::*;
#(
  parameter int ATT_W   = 8,
  parameter int FIRST_N = 16368,
  parameter int LATER_N = 2000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ratio_ok,
  input  logic           bclk_seen,
  input  logic           mute_n,
  input  logic           clocks_idle,
  input  logic           sample_tick,
  output logic           drv_en,
  output logic           drv_ramp,
  output logic [ATT_W:0] atten
);

  localparam int MAXD = (FIRST_N > LATER_N) ? FIRST_N : LATER_N;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [ATT_W:0] FULL = {1'b1, {ATT_W{1'b0}}};
  localparam logic [ATT_W:0] MAXA = {1'b0, {ATT_W{1'b1}}};
  localparam logic [ATT_W:0] ONE  = {{ATT_W{1'b0}}, 1'b1};

  seq_st_t       st, st_nxt;
  vol_cmd_t      vcmd;
  logic          first_done, set_first;
  logic          go, inst;
  logic          t_load, t_tick, t_last;
  logic [CW-1:0] t_val;

  assign go     = ratio_ok & bclk_seen & mute_n;
  assign inst   = clocks_idle & ~mute_n;
  assign t_tick = sample_tick & (st == ST_UNMUTE);
  assign t_val  = first_done ? CW'(LATER_N) : CW'(FIRST_N);

  smute_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .tick     (t_tick),
    .last     (t_last)
  );

  smute_vol #(.ATT_W(ATT_W)) u_vol (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (vcmd),
    .atten (atten)
  );

  always_comb begin
    st_nxt    = st;
    vcmd      = VC_HOLD;
    t_load    = 1'b0;
    set_first = 1'b0;
    if (st == ST_RST) begin
      st_nxt = ST_INIT;
    end else if (st == ST_INIT) begin
      if (sample_tick) st_nxt = ST_MUTE;
    end else if (inst) begin
      st_nxt = ST_INST;
      vcmd   = VC_FULL;
    end else begin
      unique case (st)
        ST_MUTE: begin
          if (go) begin
            st_nxt = ST_UNMUTE;
            t_load = 1'b1;
          end
        end
        ST_UNMUTE: begin
          if (!go) begin
            st_nxt = ST_DOWN;
          end else if (sample_tick && t_last) begin
            st_nxt    = ST_VOLUP;
            set_first = 1'b1;
          end
        end
        ST_VOLUP: begin
          if (!go) begin
            st_nxt = ST_DOWN;
          end else if (sample_tick) begin
            vcmd = VC_LOUDER;
            if (atten == ONE) st_nxt = ST_NORM;
          end
        end
        ST_NORM: begin
          if (!go) st_nxt = ST_DOWN;
        end
        ST_DOWN: begin
          if (sample_tick) begin
            if (atten >= MAXA) begin
              vcmd   = VC_FULL;
              st_nxt = ST_MUTE;
            end else begin
              vcmd = VC_SOFTER;
            end
          end
        end
        ST_INST: st_nxt = ST_MUTE;
        default: st_nxt = ST_MUTE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_RST;
      first_done <= 1'b0;
    end else begin
      st <= st_nxt;
      if (set_first) first_done <= 1'b1;
    end
  end

  assign drv_en   = (st == ST_UNMUTE) || (st == ST_VOLUP) ||
                    (st == ST_NORM)   || (st == ST_DOWN);
  assign drv_ramp = (st == ST_UNMUTE);

  // R1 / R7: whenever the driver is off the volume is at full mute
  a_r7_off_is_muted: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (atten == FULL));

  // R2: no unmute starts from mute without all conditions
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MUTE && !go) |=> !drv_ramp);

  // R3: during the driver ramp the volume stays fully muted
  a_r3_ramp_full: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ramp |-> (atten == FULL));

  // R9: instant mute cuts the driver on the next cycle
  a_r9_instant: assert property (@(posedge clk) disable iff (!rst_n)
    (inst && st != ST_RST && st != ST_INIT) |=> (!drv_en && atten == FULL));

  // R11: attenuation only moves on a sample tick unless instant mute
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && !inst) |=> $stable(atten));

endmodule

// File: tb/sim_smute_seq.sv
`timescale 1ns/1ps
module sim_smute_seq;

  localparam int ATT_W   = 8;
  localparam int FIRST_N = 40;
  localparam int LATER_N = 12;
  localparam int FULLV   = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ratio_ok, bclk_seen, mute_n, clocks_idle, sample_tick;
  logic       drv_en, drv_ramp;
  logic [8:0] atten;

  int checks = 0;
  int errors = 0;
  bit tick_on = 1'b0;
  int tick_ctr = 0;
  int ramp_ticks = 0, up_ticks = 0, dn_ticks = 0;
  int prev_att = FULLV;
  bit done = 1'b0;

  // reference model state
  int m_ph;   // 0 rst 1 init 2 mute 3 ramp 4 up 5 norm 6 down 7 cut
  int m_att;
  int m_rem;
  bit m_first;

  always #2 clk = ~clk;

  smute_seq #(.ATT_W(ATT_W), .FIRST_N(FIRST_N), .LATER_N(LATER_N)) u0 (
    .clk(clk), .rst_n(rst_n), .ratio_ok(ratio_ok), .bclk_seen(bclk_seen),
    .mute_n(mute_n), .clocks_idle(clocks_idle), .sample_tick(sample_tick),
    .drv_en(drv_en), .drv_ramp(drv_ramp), .atten(atten)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_att = FULLV; m_rem = 0; m_first = 1'b0;
    end else begin
      automatic bit g = ratio_ok && bclk_seen && mute_n;
      automatic bit c = clocks_idle && !mute_n;
      if (m_ph == 0) m_ph = 1;
      else if (m_ph == 1) begin
        if (sample_tick) m_ph = 2;
      end else if (c) begin
        m_ph = 7; m_att = FULLV;
      end else begin
        case (m_ph)
          2: if (g) begin m_ph = 3; m_rem = m_first ? LATER_N : FIRST_N; end
          3: if (!g) m_ph = 6;
             else if (sample_tick) begin
               m_rem--;
               if (m_rem == 0) begin m_ph = 4; m_first = 1'b1; end
             end
          4: if (!g) m_ph = 6;
             else if (sample_tick) begin
               m_att = (m_att == FULLV) ? 255 : m_att - 1;
               if (m_att == 0) m_ph = 5;
             end
          5: if (!g) m_ph = 6;
          6: if (sample_tick) begin
               if (m_att >= 255) begin m_att = FULLV; m_ph = 2; end
               else m_att++;
             end
          default: m_ph = 2;
        endcase
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string ph_req();
    case (m_ph)
      0, 1: return "R1";
      2: return "R2";
      3: return m_first ? "R4" : "R3";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic cyc();
    @(negedge clk);
    begin
      automatic bit e_en = (m_ph >= 3 && m_ph <= 6);
      automatic bit e_rp = (m_ph == 3);
      automatic int act = {drv_en, drv_ramp, atten};
      automatic int exp = {e_en, e_rp, 9'(m_att)};
      chk(act == exp, ph_req(), act, exp);
      if (prev_att != FULLV && atten != 9'(FULLV))
        chk((int'(atten) - prev_att <= 1) && (prev_att - int'(atten) <= 1),
            "R11", int'(atten), prev_att);
      prev_att = int'(atten);
    end
    tick_ctr++;
    sample_tick = tick_on && (tick_ctr % 2 == 0);
    if (drv_ramp && sample_tick) ramp_ticks++;
    if (drv_en && !drv_ramp && atten != 0 && sample_tick) up_ticks++;
    if (drv_en && !drv_ramp && sample_tick) dn_ticks++;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic set_go(bit r, bit b, bit m);
    ratio_ok = r; bclk_seen = b; mute_n = m;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prev_att = FULLV;
  endtask

  task automatic full_unmute(int exp_ramp, string req);
    ramp_ticks = 0; up_ticks = 0;
    set_go(1, 1, 1);
    for (int i = 0; i < 4000 && !(drv_en && !drv_ramp && atten == 0); i++) cyc();
    chk(ramp_ticks == exp_ramp, req, ramp_ticks, exp_ramp);
    chk(up_ticks == 256, "R5", up_ticks, 256);
    cyc();
    chk(drv_en && atten == 0, "R6", int'(atten), 0);
  endtask

  task automatic wait_off();
    for (int i = 0; i < 4000 && drv_en; i++) cyc();
  endtask

  initial begin
    rst_n = 1'b0; sample_tick = 1'b0; clocks_idle = 1'b0;
    set_go(1, 1, 1);
    do_reset();
    cyc();
    chk(!drv_en && !drv_ramp && atten == 9'(FULLV), "R1", int'(atten), FULLV);
    repeat (10) cyc();
    chk(!drv_en, "R1", drv_en, 0);
    tick_on = 1'b1;

    // first unmute
    full_unmute(FIRST_N, "R3");

    // lose bit clock in normal operation
    set_go(1, 0, 1);
    dn_ticks = 0;
    wait_off();
    chk(dn_ticks == 256, "R7", dn_ticks, 256);
    chk(atten == 9'(FULLV), "R7", int'(atten), FULLV);

    // each single missing condition keeps the output muted
    set_go(0, 1, 1); repeat (20) cyc(); chk(!drv_en, "R2", drv_en, 0);
    set_go(1, 0, 1); repeat (20) cyc(); chk(!drv_en, "R2", drv_en, 0);
    set_go(1, 1, 0); repeat (20) cyc(); chk(!drv_en, "R2", drv_en, 0);

    // later unmute uses the shorter ramp
    full_unmute(LATER_N, "R4");

    // lose ratio in normal operation
    set_go(0, 1, 1);
    wait_off();
    chk(atten == 9'(FULLV), "R6", int'(atten), FULLV);

    // abort during the volume ramp
    set_go(1, 1, 1);
    for (int i = 0; i < 4000 && !(drv_en && !drv_ramp && atten < 200); i++) cyc();
    begin
      automatic int held = int'(atten);
      set_go(1, 1, 0);
      cyc();
      chk(drv_en && int'(atten) == held, "R8", int'(atten), held);
    end
    wait_off();

    // abort during the driver ramp
    set_go(1, 1, 1);
    repeat (6) cyc();
    chk(drv_ramp, "R8", drv_ramp, 1);
    set_go(1, 0, 1);
    repeat (6) cyc();
    chk(!drv_en && atten == 9'(FULLV), "R8", int'(atten), FULLV);

    // instant mute from normal operation
    full_unmute(LATER_N, "R4");
    clocks_idle = 1'b1; set_go(0, 0, 0);
    cyc();
    chk(!drv_en && !drv_ramp && atten == 9'(FULLV), "R9", int'(atten), FULLV);
    repeat (10) cyc();
    chk(!drv_en, "R9", drv_en, 0);
    clocks_idle = 1'b0;
    repeat (6) cyc();
    chk(!drv_en, "R9", drv_en, 0);

    // new reset restores the long first ramp
    tick_on = 1'b0;
    do_reset();
    tick_on = 1'b1;
    full_unmute(FIRST_N, "R10");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule